// File: doc/BRIEF.md
# Four-Channel T1 Backplane Demultiplexer

This block takes one high-speed backplane stream running at 16.384 Mbit/s and splits it back into four 1.544 Mbit/s DS1 channels. Each 125 µs frame spans 2048 bit periods. Every transmitted bit occupies two consecutive bit periods. The first octet of the frame carries the four channel frame bits. Payload then follows, interleaved one timeslot at a time across the four channels. The block recovers, for every channel, its frame bit and the 24 payload octets of each frame.

Input data is sampled on the falling edge of the 16.384 MHz clock, since the sender changes data on the rising edge. A one-cycle sync pulse marks the first bit of a frame. Without it, the internal position counter free-runs. Each payload octet comes out on a shared bus together with its channel and timeslot numbers and a one-cycle strobe. The four frame bits come out together on a separate strobe. If the two copies of any meaningful bit differ, a sticky error flag is raised.

Top module: `t1_backplane_demux`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, and after it is released, fValid, payValid and pairErr are 0, and fBits, payData, payChan and paySlot are 0.
- R2: A falling clock edge that samples syncIn high treats the serIn bit sampled at that same edge as bit position 0 of a frame. This holds at any point in a frame.
- R3: Without sync the position advances by one per falling edge, modulo 2048. The first falling edge after reset release is position 0.
- R4: Positions 0 to 7 carry frame bits, two periods each, in channel order 0, 1, 2, 3. One fValid pulse follows position 7, with fBits[c] holding the frame bit of channel c.
- R5: Payload occupies positions 64 to 1599, in 16-period units. The unit index u = (position - 64) / 16 gives channel u mod 4 and timeslot u / 4. Within a unit, the eight bits arrive most significant bit first (payData[7] first), each bit twice.
- R6: Each payload unit produces exactly one single-cycle payValid pulse, with payChan and paySlot, after its last period. A frame yields 96 pulses in ascending unit order.
- R7: Positions 8 to 63 and 1600 to 2047 are ignored. Any data there produces no strobe and does not set pairErr.
- R8: For each repeated bit, the first copy is kept. If the second copy differs inside the frame-bit or payload regions, pairErr is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz bit clock; the block acts on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Multiplexed serial data |
| syncIn | input | 1 | Frame start marker, sampled with the first bit |
| fBits | output | 4 | Frame bits of channels 0 to 3 (bit c = channel c) |
| fValid | output | 1 | One-cycle strobe for fBits |
| payData | output | 8 | Recovered payload octet |
| payChan | output | 2 | Channel of payData |
| paySlot | output | 5 | Timeslot (0 to 23) of payData |
| payValid | output | 1 | One-cycle strobe for payData, payChan, paySlot |
| pairErr | output | 1 | Sticky flag for a mismatched bit pair |

## Verification
A wrong position count shows up at once as payload strobes carrying the wrong channel or timeslot. It also appears as octets shifted by a bit, and as a wrong number of strobes per frame, all within the same frame. A mishandled sync is exposed by starting a frame from the middle of an unsynchronised run of data. The next frame's frame-bit strobe and its first payload strobe must then arrive at the right position. An error flag that is not sticky, or that is raised in ignored regions, becomes visible when it is read after each frame and after a frame with no errors.

// File: rtl/t1demux_pkg.sv
package t1demux_pkg;
  localparam int CH_NUM    = 4;
  localparam int SLOT_NUM  = 24;
  localparam int FRAME_LEN = 2048;
  localparam int OCT_W     = 8;
  localparam int REP       = 2;
  localparam int PAY_OFS   = 64;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int CH_W      = $clog2(CH_NUM);
  localparam int SLOT_W    = $clog2(SLOT_NUM);
  localparam int F_LEN     = CH_NUM * REP;
  localparam int UNIT_LEN  = OCT_W * REP;
  localparam int UNIT_SH   = $clog2(UNIT_LEN);
  localparam int SLOT_SH   = UNIT_SH + CH_W;
  localparam int PAY_LEN   = SLOT_NUM * CH_NUM * UNIT_LEN;

  typedef struct packed {
    logic              firstCopy;
    logic              secondCopy;
    logic              captureF;
    logic              shiftPay;
    logic              payDone;
    logic              fDone;
    logic [CH_W-1:0]   fChan;
    logic [CH_W-1:0]   chan;
    logic [SLOT_W-1:0] slot;
  } ctrlStrobes_t;
endpackage

// File: rtl/t1demux_ctrl.sv
module t1demux_ctrl
  import t1demux_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncIn,
  output ctrlStrobes_t strobes
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] pOff;
  logic             inF;
  logic             inPay;

  // Position of the bit sampled at this falling edge
  always_comb begin
    if (syncIn)
      pos = '0;
    else if (cntQ == CNT_W'(FRAME_LEN - 1))
      pos = '0;
    else
      pos = cntQ + 1'b1;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) cntQ <= CNT_W'(FRAME_LEN - 1);
    else       cntQ <= pos;
  end

  assign inF   = (pos < CNT_W'(F_LEN));
  assign inPay = (pos >= CNT_W'(PAY_OFS)) && (pos < CNT_W'(PAY_OFS + PAY_LEN));
  assign pOff  = pos - CNT_W'(PAY_OFS);

  always_comb begin
    strobes            = '0;
    strobes.firstCopy  = (inF || inPay) && !pos[0];
    strobes.secondCopy = (inF || inPay) && pos[0];
    strobes.captureF   = inF && !pos[0];
    strobes.fChan      = pos[1 +: CH_W];
    strobes.fDone      = (pos == CNT_W'(F_LEN - 1));
    strobes.shiftPay   = inPay && !pos[0];
    strobes.payDone    = inPay && (pOff[UNIT_SH-1:0] == UNIT_SH'(UNIT_LEN - 1));
    strobes.chan       = pOff[UNIT_SH +: CH_W];
    strobes.slot       = SLOT_W'(pOff >> SLOT_SH);
  end

  // R2: a sampled sync makes the stored position zero
  assert_sync_restart_R2: assert property (@(negedge clk) disable iff (!rstN)
    syncIn |=> (cntQ == '0));
  // R3: without sync the position wraps from the last period to zero
  assert_wrap_R3: assert property (@(negedge clk) disable iff (!rstN)
    (!syncIn && cntQ == CNT_W'(FRAME_LEN - 1)) |=> (cntQ == '0));
  // R7: frame-bit and payload completions never coincide
  assert_regions_disjoint_R7: assert property (@(negedge clk) disable iff (!rstN)
    strobes.payDone |-> !strobes.fDone);
endmodule

// File: rtl/t1demux_datapath.sv
module t1demux_datapath
  import t1demux_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  ctrlStrobes_t      strobes,
  output logic [CH_NUM-1:0] fBits,
  output logic              fValid,
  output logic [OCT_W-1:0]  payData,
  output logic [CH_W-1:0]   payChan,
  output logic [SLOT_W-1:0] paySlot,
  output logic              payValid,
  output logic              pairErr
);
  logic              firstQ;
  logic [OCT_W-1:0]  shiftQ;
  logic [CH_NUM-1:0] fAcc;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      firstQ   <= 1'b0;
      shiftQ   <= '0;
      fAcc     <= '0;
      fBits    <= '0;
      fValid   <= 1'b0;
      payData  <= '0;
      payChan  <= '0;
      paySlot  <= '0;
      payValid <= 1'b0;
      pairErr  <= 1'b0;
    end else begin
      if (strobes.firstCopy) firstQ <= serIn;
      if (strobes.secondCopy && (serIn != firstQ)) pairErr <= 1'b1;
      if (strobes.captureF) fAcc[strobes.fChan] <= serIn;
      if (strobes.shiftPay) shiftQ <= {shiftQ[OCT_W-2:0], serIn};
      fValid   <= strobes.fDone;
      payValid <= strobes.payDone;
      if (strobes.fDone) fBits <= fAcc;
      if (strobes.payDone) begin
        payData <= shiftQ;
        payChan <= strobes.chan;
        paySlot <= strobes.slot;
      end
    end
  end

  assert_pay_pulse_R6: assert property (@(negedge clk) disable iff (!rstN)
    payValid |=> !payValid);
  assert_f_pulse_R4: assert property (@(negedge clk) disable iff (!rstN)
    fValid |=> !fValid);
  assert_err_sticky_R8: assert property (@(negedge clk) disable iff (!rstN)
    pairErr |=> pairErr);
  assert_slot_range_R5: assert property (@(negedge clk) disable iff (!rstN)
    payValid |-> (paySlot < SLOT_W'(SLOT_NUM)));
endmodule

// File: rtl/t1_backplane_demux.sv
module t1_backplane_demux
  import t1demux_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              syncIn,
  output logic [CH_NUM-1:0] fBits,
  output logic              fValid,
  output logic [OCT_W-1:0]  payData,
  output logic [CH_W-1:0]   payChan,
  output logic [SLOT_W-1:0] paySlot,
  output logic              payValid,
  output logic              pairErr
);
  ctrlStrobes_t strobes;

  t1demux_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .strobes (strobes)
  );

  t1demux_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .strobes  (strobes),
    .fBits    (fBits),
    .fValid   (fValid),
    .payData  (payData),
    .payChan  (payChan),
    .paySlot  (paySlot),
    .payValid (payValid),
    .pairErr  (pairErr)
  );
endmodule

// File: tb/tb_t1_backplane_demux.sv
module tb_t1_backplane_demux;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serIn = 1'b0;
  logic       syncIn = 1'b0;
  logic [3:0] fBits;
  logic       fValid;
  logic [7:0] payData;
  logic [1:0] payChan;
  logic [4:0] paySlot;
  logic       payValid;
  logic       pairErr;

  int checks = 0;
  int errors = 0;
  int curFrame = 0;
  int payCnt = 0;
  int fCnt = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  t1_backplane_demux dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .syncIn(syncIn),
    .fBits(fBits), .fValid(fValid), .payData(payData), .payChan(payChan),
    .paySlot(paySlot), .payValid(payValid), .pairErr(pairErr)
  );

  function automatic logic [7:0] expPay(int ch, int sl, int fr);
    return 8'((ch * 37 + sl * 11 + fr * 5) ^ 8'hA5);
  endfunction

  function automatic logic expF(int ch, int fr);
    return 1'(((fr + ch * 3) >> 1) & 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled on the rising edge (outputs move on the falling edge)
  always @(posedge clk) begin
    if (monOn && payValid) begin
      check(payChan == 2'(payCnt % 4), "R6 payChan order", payChan, payCnt % 4);
      check(paySlot == 5'(payCnt / 4), "R6 paySlot order", paySlot, payCnt / 4);
      check(payData == expPay(payCnt % 4, payCnt / 4, curFrame), "R5 payData",
            payData, expPay(payCnt % 4, payCnt / 4, curFrame));
      payCnt++;
    end
    if (monOn && fValid) begin
      logic [3:0] e;
      for (int c = 0; c < 4; c++) e[c] = expF(c, curFrame);
      check(fBits == e, "R4 fBits", fBits, e);
      fCnt++;
    end
  end

  // Drive one full 2048-period frame
  task automatic sendFrame(int fr, bit withSync, bit junk, int errPos, bit relRst);
    payCnt = 0;
    fCnt = 0;
    curFrame = fr;
    monOn = 1'b1;
    for (int pos = 0; pos < 2048; pos++) begin
      logic b;
      if (pos < 8) begin
        b = expF(pos / 2, fr);
      end else if (pos >= 64 && pos < 1600) begin
        int p;
        logic [7:0] d;
        p = pos - 64;
        d = expPay((p / 16) % 4, p / 64, fr);
        b = d[7 - (p % 16) / 2];
      end else begin
        b = junk ? 1'(((pos * 7) >> 2) ^ pos) : 1'b0;
      end
      if (pos == errPos) b = ~b;
      @(posedge clk);
      serIn = b;
      syncIn = withSync && (pos == 0);
      if (relRst && pos == 0) rstN = 1'b1;
    end
    check(payCnt == 96, "R6 strobes per frame", payCnt, 96);
    check(fCnt == 1, "R4 frame-bit strobes per frame", fCnt, 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    check(fValid == 0 && payValid == 0, "R1 strobes in reset", {fValid, payValid}, 0);
    check(pairErr == 0, "R1 pairErr in reset", pairErr, 0);
    check(payData == 0 && fBits == 0 && payChan == 0 && paySlot == 0,
          "R1 data outputs in reset", payData, 0);
  endtask

  task automatic testSyncStart();
    sendFrame(0, 1'b1, 1'b0, -1, 1'b1); // R2 frame aligned by sync
    check(pairErr == 0, "R1 pairErr after clean frame", pairErr, 0);
  endtask

  task automatic testFreeRun();
    sendFrame(1, 1'b0, 1'b0, -1, 1'b0); // R3 wrap without sync
  endtask

  task automatic testIgnored();
    sendFrame(2, 1'b0, 1'b1, -1, 1'b0); // R7 junk in don't-care regions
    check(pairErr == 0, "R7 junk leaves pairErr clear", pairErr, 0);
  endtask

  task automatic testResync();
    monOn = 1'b0;
    for (int i = 0; i < 700; i++) begin
      @(posedge clk);
      serIn = 1'b0;
      syncIn = 1'b0;
    end
    sendFrame(3, 1'b1, 1'b0, -1, 1'b0); // R2 sync mid-frame restarts position
  endtask

  task automatic testPairError();
    // R8: second copy of bit 2 of channel 1 timeslot 3 inverted; first copy kept,
    // so the monitor still expects the clean octet
    sendFrame(4, 1'b0, 1'b0, 64 + 13 * 16 + 5, 1'b0);
    check(pairErr == 1, "R8 mismatch sets pairErr", pairErr, 1);
    sendFrame(5, 1'b0, 1'b0, -1, 1'b0);
    check(pairErr == 1, "R8 pairErr sticky", pairErr, 1);
  endtask

  task automatic testResetAgain();
    monOn = 1'b0;
    testReset(); // R1 clears sticky flag
    sendFrame(6, 1'b0, 1'b0, -1, 1'b1); // R3 first edge after reset is position 0
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testSyncStart();
    testFreeRun();
    testIgnored();
    testResync();
    testPairError();
    testResetAgain();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule